// File: doc/BRIEF.md
# Debounced Redundant Power-Good Voter

This block turns three redundant, asynchronous power-good indications into one qualified good signal. Each raw input is brought into the clock domain through two flops and filtered on its own by a sliding K-of-N window. The window is sampled once per sample tick. The filtered channels then feed a voter. The voter runs either as any-one-of-two over channels 0 and 1, which favours availability, or as two-of-three, which suppresses false triggers.

The voted value reaches the output only after it has held steady for a minimum hold time. A hold state machine does this. Its states are `ST_LO` (output low, settled), `ST_RISE` (vote high, hold running), `ST_HI` (output high, settled) and `ST_FALL` (vote low, hold running). The transitions are:
- LO→RISE when the vote goes high.
- RISE→LO when the vote drops before the hold ends.
- RISE→HI when the hold ends.
- HI→FALL when the vote goes low.
- FALL→HI when the vote recovers before the hold ends.
- FALL→LO when the hold ends.

A participating channel that disagrees with the vote for longer than a timeout is removed from the vote, and a failover request is issued. The isolation flags and the failover budget stay as they are until the clear input is asserted. A downstream watchdog kick is passed on only while the output is good and settled.

Top module: `pg_vote_guard`

## Requirements
- R1: Each channel's filtered state goes high once at least DEB_K of its last DEB_N tick samples are high, and goes low once at most DEB_N-DEB_K of them are high. A raw pulse shorter than one sample interval never changes the voted output.
- R2: With `vote_2oo3`=0, the vote is high when channel 0 or channel 1 is active and filtered high. Channel 2 never affects the vote and is never isolated in this mode.
- R3: With `vote_2oo3`=1 and all three channels active, the vote is high when two or more filtered channels are high.
- R4: `pg_good` follows the vote only after the vote has held its new value for HOLD_CYC consecutive cycles. A shorter excursion leaves `pg_good` unchanged.
- R5: `pg_stable` is high in ST_LO and ST_HI, and low in ST_RISE and ST_FALL.
- R6: An active, participating channel whose filtered state differs from the vote for TIMEOUT_CYC consecutive cycles sets its bit in `iso_flags` (bit i is channel i). The bit stays set until `iso_clear` is high at a clock edge, and it is cleared at that edge.
- R7: Each isolation event gives a one-cycle `failover_req` pulse, but only while fewer than RETRY_MAX pulses have been issued since the last clear. `iso_clear` restores the budget.
- R8: `wd_kick_out` equals `wd_kick_in` while `pg_good` and `pg_stable` are both high, and is 0 otherwise.
- R9: In two-of-three mode with fewer than three active channels, every active channel must be high for the vote to be high: both of two, or the single one left. With none active, the vote is low.
- R10: After reset, `pg_good`=0, `pg_stable`=1, `iso_flags`=0 and `failover_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_raw | input | 3 | Raw asynchronous power-good indications, bit i = channel i |
| vote_2oo3 | input | 1 | 1 = two-of-three voting, 0 = one-of-two over channels 0 and 1 |
| iso_clear | input | 1 | Clears isolation flags and failover budget |
| wd_kick_in | input | 1 | Watchdog kick to be gated |
| pg_good | output | 1 | Held, voted power-good |
| pg_stable | output | 1 | Output settled, no change pending |
| iso_flags | output | 3 | Per-channel isolation flags |
| failover_req | output | 1 | One-cycle failover request pulse |
| wd_kick_out | output | 1 | Gated watchdog kick |

## Verification
The voter is driven with several input patterns:
- All three channels high.
- A single minority channel low.
- Two dissenting channels, with one already isolated.
- A single surviving channel.
- A split between channels 0 and 1 with channel 2 opposed in one-of-two mode.

Together these separate majority voting, the reduced-set fallback and the one-of-two rule. A raw pulse shorter than a sample tick, and a full dip shorter than the hold time, show that both the filter and the hold reject short events, and the dip also shows the watchdog gate closing. Repeated isolations with no clear in between, and then after a clear, show the failover budget and the sticky flags.

// File: rtl/pgv_pkg.sv
package pgv_pkg;
    localparam int NCH = 3;

    typedef enum logic [1:0] {
        ST_LO   = 2'd0,
        ST_RISE = 2'd1,
        ST_HI   = 2'd2,
        ST_FALL = 2'd3
    } hold_st_t;
endpackage

// File: rtl/pgv_chan_filter.sv
module pgv_chan_filter #(
    parameter int DEB_N = 5,
    parameter int DEB_K = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic deb
);
    localparam int CW = $clog2(DEB_N + 1);
    localparam logic [CW-1:0] HI_TH = CW'(DEB_K);
    localparam logic [CW-1:0] LO_TH = CW'(DEB_N - DEB_K);

    logic              s1, s2;
    logic [DEB_N-1:0]  win, win_nx;
    logic [CW-1:0]     ones;

    always_comb begin
        win_nx = {win[DEB_N-2:0], s2};
        ones   = '0;
        for (int i = 0; i < DEB_N; i++) begin
            ones = ones + CW'(win_nx[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            win <= '0;
            deb <= 1'b0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (tick) begin
                win <= win_nx;
                if (ones >= HI_TH) begin
                    deb <= 1'b1;
                end else if (ones <= LO_TH) begin
                    deb <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pgv_voter.sv
module pgv_voter
    import pgv_pkg::*;
(
    input  logic [NCH-1:0] deb,
    input  logic [NCH-1:0] iso,
    input  logic           mode_3,
    output logic           vote
);
    logic [NCH-1:0] act, good;
    logic [1:0]     n_act, n_good;

    always_comb begin
        act    = ~iso;
        good   = deb & act;
        n_act  = '0;
        n_good = '0;
        for (int i = 0; i < NCH; i++) begin
            n_act  = n_act + 2'(act[i]);
            n_good = n_good + 2'(good[i]);
        end
        if (!mode_3) begin
            vote = good[0] | good[1];
        end else if (n_act == 2'd3) begin
            vote = (n_good >= 2'd2);
        end else begin
            vote = (n_act != 2'd0) && (n_good == n_act);
        end
    end
endmodule

// File: rtl/pgv_isolator.sv
module pgv_isolator
    import pgv_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int RETRY_MAX   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] deb,
    input  logic           vote,
    input  logic           mode_3,
    input  logic           iso_clear,
    output logic [NCH-1:0] iso,
    output logic           failover_req
);
    localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam int RW = $clog2(RETRY_MAX + 1);
    localparam logic [TW-1:0] TO_LAST   = TW'(TIMEOUT_CYC - 1);
    localparam logic [RW-1:0] RETRY_LIM = RW'(RETRY_MAX);

    logic [NCH-1:0] hit;
    logic [RW-1:0]  req_cnt;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic          part, dis;
        logic [TW-1:0] cnt;

        if (i < 2) begin : g_always
            assign part = 1'b1;
        end else begin : g_maj_only
            assign part = mode_3;
        end

        assign dis    = part && !iso[i] && (deb[i] != vote);
        assign hit[i] = dis && (cnt == TO_LAST);

        always_ff @(posedge clk) begin
            if (!rst_n || iso_clear || !dis) begin
                cnt <= '0;
            end else if (!hit[i]) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || iso_clear) begin
            iso          <= '0;
            req_cnt      <= '0;
            failover_req <= 1'b0;
        end else begin
            iso <= iso | hit;
            if ((|hit) && (req_cnt < RETRY_LIM)) begin
                req_cnt      <= req_cnt + 1'b1;
                failover_req <= 1'b1;
            end else begin
                failover_req <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgv_hold_fsm.sv
module pgv_hold_fsm
    import pgv_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vote,
    input  logic wd_kick_in,
    output logic pg_good,
    output logic pg_stable,
    output logic wd_kick_out
);
    localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

    hold_st_t      st, st_nx;
    logic [HW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == HOLD_LAST);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_LO:   if (vote) st_nx = ST_RISE;
            ST_RISE: begin
                if (!vote)        st_nx = ST_LO;
                else if (at_last) st_nx = ST_HI;
            end
            ST_HI:   if (!vote) st_nx = ST_FALL;
            ST_FALL: begin
                if (vote)         st_nx = ST_HI;
                else if (at_last) st_nx = ST_LO;
            end
            default: st_nx = ST_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_LO;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (st_nx != st) begin
                cnt <= '0;
            end else if (!at_last) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        pg_good     = (st == ST_HI) || (st == ST_FALL);
        pg_stable   = (st == ST_HI) || (st == ST_LO);
        wd_kick_out = wd_kick_in && (st == ST_HI);
    end
endmodule

// File: rtl/pg_vote_guard.sv
module pg_vote_guard
    import pgv_pkg::*;
#(
    parameter int SAMPLE_DIV  = 160000,
    parameter int DEB_N       = 5,
    parameter int DEB_K       = 3,
    parameter int HOLD_CYC    = 1000000,
    parameter int TIMEOUT_CYC = 5000000,
    parameter int RETRY_MAX   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pg_raw,
    input  logic           vote_2oo3,
    input  logic           iso_clear,
    input  logic           wd_kick_in,
    output logic           pg_good,
    output logic           pg_stable,
    output logic [NCH-1:0] iso_flags,
    output logic           failover_req,
    output logic           wd_kick_out
);
    logic           tick;
    logic [NCH-1:0] deb_w;
    logic           vote_w;

    if (SAMPLE_DIV == 1) begin : g_tick_every
        assign tick = 1'b1;
    end else begin : g_tick_div
        localparam int DW = $clog2(SAMPLE_DIV);
        localparam logic [DW-1:0] DIV_LAST = DW'(SAMPLE_DIV - 1);
        logic [DW-1:0] div_cnt;
        always_ff @(posedge clk) begin
            if (!rst_n || div_cnt == DIV_LAST) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
        assign tick = (div_cnt == DIV_LAST);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_filt
        pgv_chan_filter #(
            .DEB_N (DEB_N),
            .DEB_K (DEB_K)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .raw   (pg_raw[i]),
            .deb   (deb_w[i])
        );
    end

    pgv_voter u_vote (
        .deb    (deb_w),
        .iso    (iso_flags),
        .mode_3 (vote_2oo3),
        .vote   (vote_w)
    );

    pgv_isolator #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .RETRY_MAX   (RETRY_MAX)
    ) u_iso (
        .clk          (clk),
        .rst_n        (rst_n),
        .deb          (deb_w),
        .vote         (vote_w),
        .mode_3       (vote_2oo3),
        .iso_clear    (iso_clear),
        .iso          (iso_flags),
        .failover_req (failover_req)
    );

    pgv_hold_fsm #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .vote        (vote_w),
        .wd_kick_in  (wd_kick_in),
        .pg_good     (pg_good),
        .pg_stable   (pg_stable),
        .wd_kick_out (wd_kick_out)
    );
endmodule

// File: rtl/pgv_checker.sv
module pgv_checker #(
    parameter int HOLD_CYC = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       vote,
    input logic       iso_clear,
    input logic [2:0] iso_flags,
    input logic       failover_req,
    input logic       pg_good,
    input logic       pg_stable,
    input logic       wd_kick_out
);
    localparam int CW = $clog2(HOLD_CYC + 2);
    localparam logic [CW-1:0] SAT = CW'(HOLD_CYC + 1);
    localparam logic [CW-1:0] NEED = CW'(HOLD_CYC);

    logic [CW-1:0] hi_run, lo_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= vote ? ((hi_run == SAT) ? SAT : hi_run + 1'b1) : '0;
            lo_run <= !vote ? ((lo_run == SAT) ? SAT : lo_run + 1'b1) : '0;
        end
    end

    assert_hold_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_good) |-> (hi_run >= NEED));

    assert_hold_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_good) |-> (lo_run >= NEED));

    assert_iso_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~iso_flags & $past(iso_flags)) != 3'b000) |-> $past(iso_clear));

    assert_failover_new_iso_R7: assert property (@(posedge clk) disable iff (!rst_n)
        failover_req |-> ($countones(iso_flags) > $countones($past(iso_flags))));

    assert_wdt_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_kick_out |-> (pg_good && pg_stable));
endmodule

bind pg_vote_guard pgv_checker #(
    .HOLD_CYC (HOLD_CYC)
) u_pgv_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vote         (vote_w),
    .iso_clear    (iso_clear),
    .iso_flags    (iso_flags),
    .failover_req (failover_req),
    .pg_good      (pg_good),
    .pg_stable    (pg_stable),
    .wd_kick_out  (wd_kick_out)
);

// File: tb/tb_pg_vote_guard.sv
module tb_pg_vote_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pg_raw = 3'b000;
    logic       vote_2oo3 = 1'b0;
    logic       iso_clear = 1'b0;
    logic       wd_kick_in = 1'b1;
    logic       pg_good, pg_stable, failover_req, wd_kick_out;
    logic [2:0] iso_flags;

    int checks = 0;
    int failures = 0;
    int fo_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pg_vote_guard #(
        .SAMPLE_DIV  (4),
        .DEB_N       (5),
        .DEB_K       (3),
        .HOLD_CYC    (40),
        .TIMEOUT_CYC (120),
        .RETRY_MAX   (1)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pg_raw       (pg_raw),
        .vote_2oo3    (vote_2oo3),
        .iso_clear    (iso_clear),
        .wd_kick_in   (wd_kick_in),
        .pg_good      (pg_good),
        .pg_stable    (pg_stable),
        .iso_flags    (iso_flags),
        .failover_req (failover_req),
        .wd_kick_out  (wd_kick_out)
    );

    always @(negedge clk) if (rst_n && failover_req) fo_seen++;

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk) iso_clear = 1'b1;
        @(negedge clk) iso_clear = 1'b0;
    endtask

    task automatic t_reset();
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        check("R10", "pg_good", int'(pg_good), 0);
        check("R10", "pg_stable", int'(pg_stable), 1);
        check("R10", "iso_flags", int'(iso_flags), 0);
        check("R10", "failover_req", int'(failover_req), 0);
        check("R8", "wd_kick_out while not good", int'(wd_kick_out), 0);
    endtask

    // R1: a 3-cycle raw pulse is shorter than one 4-cycle sample interval
    task automatic t_short_raw_pulse();
        int unstable = 0;
        vote_2oo3 = 1'b0;
        wait_n(30);
        @(negedge clk) pg_raw = 3'b001;
        wait_n(3);
        pg_raw = 3'b000;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (pg_good || !pg_stable) unstable++;
        end
        check("R1", "cycles disturbed by short raw pulse", unstable, 0);
    endtask

    // R3 R4 R5 R8: all channels rise in two-of-three mode
    task automatic t_rise_all();
        vote_2oo3 = 1'b1;
        @(negedge clk) pg_raw = 3'b111;
        wait_n(30);
        check("R4", "pg_good before hold expires", int'(pg_good), 0);
        check("R5", "pg_stable while rise pending", int'(pg_stable), 0);
        wait_n(70);
        check("R3", "pg_good with 3 of 3 high", int'(pg_good), 1);
        check("R5", "pg_stable settled high", int'(pg_stable), 1);
        check("R8", "wd_kick_out when good and stable", int'(wd_kick_out), 1);
    endtask

    // R4 R8: a 25-cycle dip on all channels is shorter than the hold
    task automatic t_short_dip();
        int lows = 0;
        int kicks_blocked = 0;
        @(negedge clk) pg_raw = 3'b000;
        for (int i = 0; i < 100; i++) begin
            if (i == 25) pg_raw = 3'b111;
            @(negedge clk);
            if (!pg_good) lows++;
            if (!wd_kick_out) kicks_blocked++;
        end
        check("R4", "pg_good low cycles during short dip", lows, 0);
        check("R8", "kick blocked during pending fall", int'(kicks_blocked > 0), 1);
        check("R8", "kick passes after recovery", int'(wd_kick_out), 1);
    endtask

    // R3 R6 R7: channel 2 alone drops
    task automatic t_minority();
        pulse_clear();
        @(negedge clk) pg_raw = 3'b011;
        wait_n(60);
        check("R3", "pg_good with 2 of 3 high", int'(pg_good), 1);
        check("R6", "no isolation before timeout", int'(iso_flags), 0);
        wait_n(240);
        check("R6", "channel 2 isolated", int'(iso_flags), 3'b100);
        check("R7", "failover pulses after first isolation", fo_seen, 1);
        check("R3", "pg_good kept", int'(pg_good), 1);
    endtask

    // R9 R6 R7: reduced active set
    task automatic t_fallback();
        @(negedge clk) pg_raw = 3'b001;
        wait_n(150);
        check("R9", "two active, one high -> low", int'(pg_good), 0);
        wait_n(150);
        check("R6", "channel 0 isolated too", int'(iso_flags), 3'b101);
        check("R7", "no pulse beyond retry budget", fo_seen, 1);
        @(negedge clk) pg_raw = 3'b010;
        wait_n(150);
        check("R9", "single active high -> good", int'(pg_good), 1);
    endtask

    // R6: clear
    task automatic t_clear();
        @(negedge clk) pg_raw = 3'b111;
        wait_n(100);
        pulse_clear();
        check("R6", "flags after clear", int'(iso_flags), 0);
        wait_n(200);
        check("R6", "flags stay clear with agreement", int'(iso_flags), 0);
        check("R3", "pg_good all high", int'(pg_good), 1);
    endtask

    // R2 R7: one-of-two mode
    task automatic t_one_of_two();
        vote_2oo3 = 1'b0;
        @(negedge clk) pg_raw = 3'b100;
        wait_n(150);
        check("R2", "channel 2 alone high -> low", int'(pg_good), 0);
        wait_n(200);
        check("R2", "channel 2 never isolated", int'(iso_flags), 0);
        @(negedge clk) pg_raw = 3'b010;
        wait_n(150);
        check("R2", "channel 1 alone high -> good", int'(pg_good), 1);
        wait_n(200);
        check("R6", "channel 0 isolated in 1oo2", int'(iso_flags), 3'b001);
        check("R7", "budget restored by clear", fo_seen, 2);
    endtask

    initial begin
        t_reset();
        t_short_raw_pulse();
        t_rise_all();
        t_short_dip();
        t_minority();
        t_fallback();
        t_clear();
        t_one_of_two();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule